// File: doc/BRIEF.md
# Key Event FIFO with Unread Counter

This block buffers events coming from a keypad scanner and from general-purpose input change logic until a host gets around to reading them. Each event is one byte: bit 7 says whether the event is a press (or input active) and bits 6:0 carry the event code. The buffer holds up to `DEPTH` unread bytes, ten by default. A live count of unread entries is always visible.

The producer raises `wrEn` for one cycle with the byte on `wrData`. The host sees the oldest unread byte on `rdData` at all times, or 0x00 when nothing is pending. It pulses `rdEn` to consume that byte. When the buffer is full and another event arrives without a read, the oldest entry is discarded and the new one goes in. The count stays at its maximum and a sticky overflow flag is raised. The host clears that flag with a write-one-to-clear strobe. An interrupt request combines "events pending" and "overflow", and each source can be masked.

Top module: `key_evt_fifo`

## Requirements
- R1: After reset, `evtCount` is 0, `ovfFlag` is 0, `irqReq` is 0 and `rdData` is 0x00.
- R2: A `wrEn` pulse on a non-full buffer without `rdEn` appends `wrData` behind all unread entries and raises `evtCount` by one at the next clock edge.
- R3: `rdData` shows the oldest unread entry. A `rdEn` pulse on a non-empty buffer without `wrEn` removes that entry and lowers `evtCount` by one, and the next-oldest entry then appears on `rdData`.
- R4: With `evtCount` at 0, `rdData` is 0x00, and a `rdEn` pulse leaves `evtCount` at 0.
- R5: A `wrEn` pulse without `rdEn` while `DEPTH` entries are held drops the oldest entry and stores the new byte as the newest. `evtCount` stays at `DEPTH` and `ovfFlag` becomes 1 at the next edge. `evtCount` never exceeds `DEPTH`.
- R6: `ovfFlag` stays at 1 until an `ovfClr` pulse clears it at the next edge. If a new overflow occurs in the same cycle as `ovfClr`, the flag stays set.
- R7: When `wrEn` and `rdEn` are both high on a non-empty buffer, the oldest entry is consumed, the new byte is appended and `evtCount` is unchanged. This also applies when the buffer is full, and no overflow is raised. On an empty buffer the read has no effect and `evtCount` becomes 1.
- R8: `irqReq` is high exactly when (`evtIntEn` and `evtCount` is non-zero) or (`ovfIntEn` and `ovfFlag` is set).
- R9: All eight bits of each entry are returned unchanged, covering both press (bit 7 = 1) and release (bit 7 = 0) key codes and input-event codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Event strobe from scanner or input logic |
| wrData | input | 8 | Event byte: bit 7 press/active, bits 6:0 code |
| rdEn | input | 1 | Host read strobe, pops the oldest entry |
| rdData | output | 8 | Oldest unread entry, 0x00 when empty |
| evtCount | output | $clog2(DEPTH+1) | Number of unread entries |
| ovfClr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| ovfFlag | output | 1 | Sticky overflow status |
| evtIntEn | input | 1 | Enables the events-pending interrupt source |
| ovfIntEn | input | 1 | Enables the overflow interrupt source |
| irqReq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the count bound;
- the count stepping by one on a lone push or a lone pop;
- the count holding steady when a push and a pop coincide;
- the wrap raising the overflow flag;
- the flag's stickiness and its clearing;
- the empty buffer reading as zero;
- the interrupt following its enabled sources.

Only the bench scenarios can show that the bytes come out in arrival order, with every bit intact. They also show that a wrap discards exactly the oldest entry, and what happens when a push and a pop land on a full or an empty buffer.

// File: rtl/key_evt_pkg.sv
package key_evt_pkg;
  localparam int EVT_W = 8;

  typedef struct packed {
    logic shift;      // move every entry one slot toward the head
    logic load;       // write wrData into slot loadIdx
    logic headValid;  // slot 0 holds an unread entry
  } fifoCtrl_t;
endpackage

// File: rtl/key_evt_ctrl.sv
module key_evt_ctrl
  import key_evt_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             ovfClr,
  input  logic             evtIntEn,
  input  logic             ovfIntEn,
  output fifoCtrl_t        ctrl,
  output logic [CNT_W-1:0] loadIdx,
  output logic [CNT_W-1:0] evtCount,
  output logic             ovfFlag,
  output logic             irqReq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic notEmpty, isFull, popEff, wrapEv;

  assign notEmpty = (evtCount != '0);
  assign isFull   = (evtCount == FULL_CNT);
  assign popEff   = rdEn && notEmpty;
  assign wrapEv   = wrEn && isFull && !popEff;

  always_comb begin
    ctrl.shift     = popEff || wrapEv;
    ctrl.load      = wrEn;
    ctrl.headValid = notEmpty;
    loadIdx        = evtCount - CNT_W'(ctrl.shift);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCount <= '0;
    end else if (wrEn && !wrapEv && !popEff) begin
      evtCount <= evtCount + 1'b1;
    end else if (popEff && !wrEn) begin
      evtCount <= evtCount - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (wrapEv) begin
      ovfFlag <= 1'b1;
    end else if (ovfClr) begin
      ovfFlag <= 1'b0;
    end
  end

  assign irqReq = (evtIntEn && notEmpty) || (ovfIntEn && ovfFlag);
endmodule

// File: rtl/key_evt_store.sv
module key_evt_store
  import key_evt_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtrl_t        ctrl,
  input  logic [CNT_W-1:0] loadIdx,
  input  logic [EVT_W-1:0] wrData,
  output logic [EVT_W-1:0] rdData
);
  logic [EVT_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [EVT_W-1:0] upstream;
    logic [EVT_W-1:0] slotNext;

    if (i == DEPTH - 1) begin : g_tail
      assign upstream = '0;
    end else begin : g_mid
      assign upstream = slot[i+1];
    end

    always_comb begin
      slotNext = ctrl.shift ? upstream : slot[i];
      if (ctrl.load && (loadIdx == CNT_W'(i))) begin
        slotNext = wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slot[i] <= '0;
      end else begin
        slot[i] <= slotNext;
      end
    end
  end

  assign rdData = ctrl.headValid ? slot[0] : '0;
endmodule

// File: rtl/key_evt_fifo.sv
module key_evt_fifo
  import key_evt_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             rdEn,
  output logic [7:0]       rdData,
  output logic [CNT_W-1:0] evtCount,
  input  logic             ovfClr,
  output logic             ovfFlag,
  input  logic             evtIntEn,
  input  logic             ovfIntEn,
  output logic             irqReq
);
  fifoCtrl_t        ctrl;
  logic [CNT_W-1:0] loadIdx;

  key_evt_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .ovfClr(ovfClr),
    .evtIntEn(evtIntEn), .ovfIntEn(ovfIntEn), .ctrl(ctrl), .loadIdx(loadIdx),
    .evtCount(evtCount), .ovfFlag(ovfFlag), .irqReq(irqReq)
  );

  key_evt_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadIdx(loadIdx),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/key_evt_fifo_chk.sv
module key_evt_fifo_chk #(
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [7:0]       rdData,
  input logic [CNT_W-1:0] evtCount,
  input logic             ovfClr,
  input logic             ovfFlag,
  input logic             evtIntEn,
  input logic             ovfIntEn,
  input logic             irqReq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtCount <= FULL_CNT);

  p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount == '0) |-> (rdData == 8'h00));

  p_push_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && evtCount < FULL_CNT) |=> (evtCount == $past(evtCount) + 1'b1));

  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && evtCount != '0) |=> (evtCount == $past(evtCount) - 1'b1));

  p_wrap_ovf_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && evtCount == FULL_CNT) |=> (ovfFlag && evtCount == FULL_CNT));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !(wrEn && !rdEn && evtCount == FULL_CNT)) |=> !ovfFlag);

  p_both_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && evtCount != '0) |=> $stable(evtCount));

  p_irq_ovf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfIntEn && ovfFlag) |-> irqReq);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!evtIntEn && !ovfIntEn) |-> !irqReq);
endmodule

bind key_evt_fifo key_evt_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .evtCount(evtCount), .ovfClr(ovfClr), .ovfFlag(ovfFlag),
  .evtIntEn(evtIntEn), .ovfIntEn(ovfIntEn), .irqReq(irqReq)
);

// File: tb/key_evt_fifo_tb.sv
module key_evt_fifo_tb_top;
  localparam int DEPTH = 10;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, ovfClr = 1'b0;
  logic evtIntEn = 1'b0, ovfIntEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [CNT_W-1:0] evtCount;
  logic ovfFlag, irqReq;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [$];

  always #2 clk = ~clk;

  key_evt_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .evtCount(evtCount), .ovfClr(ovfClr), .ovfFlag(ovfFlag),
    .evtIntEn(evtIntEn), .ovfIntEn(ovfIntEn), .irqReq(irqReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0;
    if (mdl.size() == DEPTH) void'(mdl.pop_front());
    mdl.push_back(d);
  endtask

  task automatic drain(input string req);
    while (mdl.size() > 0) begin
      check(req, rdData, mdl.pop_front());
      rdEn = 1'b1;
      step();
      rdEn = 1'b0;
      check(req, evtCount, mdl.size());
    end
  endtask

  task automatic t_reset();
    check("R1 count", evtCount, 0);
    check("R1 ovf", ovfFlag, 0);
    check("R1 irq", irqReq, 0);
    check("R1 rdData", rdData, 0);
  endtask

  task automatic t_order();
    push(8'h81); check("R2 count", evtCount, 1);
    push(8'h05); check("R2 count", evtCount, 2);
    push(8'hE5); check("R2 count", evtCount, 3);
    push(8'h65); check("R9 count", evtCount, 4);
    check("R3 head", rdData, 8'h81);
    drain("R3 R9 order");
  endtask

  task automatic t_empty_read();
    check("R4 data", rdData, 0);
    rdEn = 1'b1; step(); rdEn = 1'b0;
    check("R4 count", evtCount, 0);
    check("R4 data after", rdData, 0);
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= DEPTH; i++) push(8'(i));
    check("R5 full count", evtCount, DEPTH);
    check("R5 no ovf yet", ovfFlag, 0);
    push(8'hC1);
    push(8'h42);
    check("R5 count held", evtCount, DEPTH);
    check("R5 ovf set", ovfFlag, 1);
    check("R5 oldest dropped", rdData, 8'h03);
    drain("R5 contents");
  endtask

  task automatic t_ovf_clear();
    step();
    check("R6 sticky", ovfFlag, 1);
    ovfClr = 1'b1; step(); ovfClr = 1'b0;
    check("R6 cleared", ovfFlag, 0);
    for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i));
    wrEn = 1'b1; wrData = 8'h77; ovfClr = 1'b1;
    step();
    wrEn = 1'b0; ovfClr = 1'b0;
    void'(mdl.pop_front()); mdl.push_back(8'h77);
    check("R6 set wins", ovfFlag, 1);
    ovfClr = 1'b1; step(); ovfClr = 1'b0;
  endtask

  task automatic t_simul();
    check("R7 full start", evtCount, DEPTH);
    check("R7 head", rdData, mdl[0]);
    wrEn = 1'b1; rdEn = 1'b1; wrData = 8'h9A;
    step();
    wrEn = 1'b0; rdEn = 1'b0;
    void'(mdl.pop_front()); mdl.push_back(8'h9A);
    check("R7 count full", evtCount, DEPTH);
    check("R7 no ovf", ovfFlag, 0);
    drain("R7 contents");
    wrEn = 1'b1; rdEn = 1'b1; wrData = 8'h33;
    step();
    wrEn = 1'b0; rdEn = 1'b0;
    mdl.push_back(8'h33);
    check("R7 empty both", evtCount, 1);
    check("R7 empty data", rdData, 8'h33);
    push(8'h34);
    wrEn = 1'b1; rdEn = 1'b1; wrData = 8'h35;
    step();
    wrEn = 1'b0; rdEn = 1'b0;
    void'(mdl.pop_front()); mdl.push_back(8'h35);
    check("R7 mid count", evtCount, 2);
    drain("R7 mid contents");
  endtask

  task automatic t_irq();
    evtIntEn = 1'b0; ovfIntEn = 1'b1; #1;
    check("R8 empty no ovf", irqReq, 0);
    push(8'h01);
    check("R8 masked evt", irqReq, 0);
    evtIntEn = 1'b1; #1;
    check("R8 evt pending", irqReq, 1);
    drain("R8 drain");
    check("R8 after drain", irqReq, 0);
    evtIntEn = 1'b0;
    for (int i = 0; i <= DEPTH; i++) push(8'h20 + 8'(i));
    check("R8 ovf irq", irqReq, 1);
    ovfIntEn = 1'b0; #1;
    check("R8 ovf masked", irqReq, 0);
    drain("R8 drain2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    t_reset();
    t_order();
    t_empty_read();
    t_overflow();
    t_ovf_clear();
    t_simul();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule